// File: doc/BRIEF.md
# Tight-Loop Fetch Suppression Controller

This controller sits beside a processor's retire stage. It watches the stream of retired instruction descriptors for one loop shape: a one-word instruction that does not change program flow, followed directly by a decrement-and-branch-on-condition instruction. The branch must carry a backward displacement of -4, so that it targets that one-word instruction. The first time the branch is taken, the controller captures the looped instruction word and its address and enters loop mode. From then on it holds instruction fetch requests off, presents the captured word for replay, and lets only the data cycles of that instruction run.

Each time the datapath signals that the replayed instruction's data operations have finished, the controller evaluates the branch condition and the 16-bit loop count. It decrements the count and writes it back, or it ends the loop. A termination produces a one-cycle redirect to the address after the branch, and fetching resumes in the following cycle. An exception request cancels loop mode at once. The controller releases fetch suppression combinationally in that same cycle and reports the looped instruction's address, so that the handler returns into the loop in normal mode.

Top module: `loop_fetch_gate`

## Requirements
- R1: Loop mode is entered only in the cycle after a retired descriptor with `rv_dbcc=1` and `rv_disp=16'hFFFC` whose `rv_pc` is exactly 2 above the previous retired descriptor's `rv_pc`. Any other displacement keeps `loop_active=0`.
- R2: The previous retired descriptor must have `rv_single=1`, `rv_flow=0` and `rv_dbcc=0`. A multi-word or flow-changing predecessor keeps `loop_active=0`.
- R3: While `loop_active=1` and `exc_req=0`, `fetch_suppress=1`. `replay_word` equals the `rv_word` captured from the looped instruction.
- R4: In loop mode, on a cycle with `iter_done=1` and `exc_req=0`: if `cond_met=1` the loop terminates and `cnt_we=0`. Otherwise `cnt_we=1` and `cnt_wdata=cnt_in-1` (16 bits), and the loop terminates when that value is 16'hFFFF. `cnt_we` is 0 outside loop mode.
- R5: With `exc_req=1` during loop mode, `fetch_suppress=0` and `exc_exit=1` in the same cycle. `resume_pc` equals the looped instruction's address and `cnt_we=0`. `loop_active` is 0 in the next cycle and no redirect follows.
- R6: One cycle after a terminating iteration, `loop_active=0`, `fetch_suppress=1` and `redirect_valid=1`, with `redirect_pc` equal to the branch address plus 4. In the cycle after that, `fetch_suppress=0` and `redirect_valid=0`.
- R7: The first pass runs in normal mode: `fetch_suppress=0` while the qualifying branch retires. Entry happens only if that branch is taken, meaning `cond_met=0` and `cnt_in-1` is not 16'hFFFF.
- R8: A synchronous active-high `rst` clears `loop_active`, `fetch_suppress`, `redirect_valid` and `cnt_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rv_valid | input | 1 | A descriptor retires this cycle |
| rv_pc | input | 32 | Address of the retiring instruction |
| rv_word | input | 16 | First opcode word of the retiring instruction |
| rv_single | input | 1 | Instruction is one word long |
| rv_flow | input | 1 | Instruction changes program flow |
| rv_dbcc | input | 1 | Instruction is a decrement-and-branch |
| rv_disp | input | 16 | Branch displacement of a decrement-and-branch |
| cond_met | input | 1 | Termination condition of the branch is true |
| cnt_in | input | 16 | Current low half of the loop counter register |
| iter_done | input | 1 | Data operations of the replayed instruction finished |
| exc_req | input | 1 | Interrupt or other exception request |
| fetch_suppress | output | 1 | Instruction fetch requests held off |
| loop_active | output | 1 | Loop mode is active |
| replay_word | output | 16 | Captured looped instruction word |
| cnt_we | output | 1 | Counter write-back strobe |
| cnt_wdata | output | 16 | Decremented counter value |
| redirect_valid | output | 1 | Redirect fetch to the fall-through address |
| redirect_pc | output | 32 | Fall-through address (branch address + 4) |
| exc_exit | output | 1 | Loop cancelled by an exception this cycle |
| resume_pc | output | 32 | Return address reported on an exception exit |

## Verification
The assertions assume that the datapath raises `iter_done` only while the controller reports loop mode. They also assume that `cnt_in` holds the counter value from before the current iteration's decrement. The bench drives `iter_done` only after it has seen `loop_active` high. Between iterations it feeds back the last written count itself, and it never presents retire descriptors while a loop is running. Exceptions are raised both on a cycle with `iter_done` and on a cycle without it, so the rule that the exception wins over a pending write-back is exercised.

// File: rtl/loop_fetch_pkg.sv
package loop_fetch_pkg;
    typedef enum logic [1:0] {
        LS_IDLE = 2'd0,
        LS_LOOP = 2'd1,
        LS_EXIT = 2'd2
    } loop_state_e;
endpackage

// File: rtl/loop_iter_eval.sv
module loop_iter_eval #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             cond_met,
    output logic [CNT_W-1:0] cnt_dec,
    output logic             take_branch
);
    localparam logic [CNT_W-1:0] CNT_EXPIRED = '1;

    always_comb begin
        cnt_dec     = cnt_in - CNT_W'(1);
        take_branch = !cond_met && (cnt_dec != CNT_EXPIRED);
    end
endmodule

// File: rtl/loop_shape_detect.sv
module loop_shape_detect #(
    parameter int              ADDR_W      = 32,
    parameter int              WORD_W      = 16,
    parameter int              DISP_W      = 16,
    parameter logic [DISP_W-1:0] LOOP_DISP = 16'hFFFC,
    parameter int              INSTR_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rv_valid,
    input  logic [ADDR_W-1:0] rv_pc,
    input  logic [WORD_W-1:0] rv_word,
    input  logic              rv_single,
    input  logic              rv_flow,
    input  logic              rv_dbcc,
    input  logic [DISP_W-1:0] rv_disp,
    input  logic              exc_req,
    input  logic              in_loop,
    output logic              shape_hit,
    output logic [ADDR_W-1:0] body_pc,
    output logic [WORD_W-1:0] body_word
);
    logic              prev_ok_d, prev_ok_q;
    logic [ADDR_W-1:0] prev_pc_d, prev_pc_q;
    logic [WORD_W-1:0] prev_word_d, prev_word_q;

    always_comb begin
        prev_ok_d   = prev_ok_q;
        prev_pc_d   = prev_pc_q;
        prev_word_d = prev_word_q;
        if (exc_req || in_loop) begin
            prev_ok_d = 1'b0;
        end else if (rv_valid) begin
            prev_ok_d   = rv_single && !rv_flow && !rv_dbcc;
            prev_pc_d   = rv_pc;
            prev_word_d = rv_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ok_q   <= 1'b0;
            prev_pc_q   <= '0;
            prev_word_q <= '0;
        end else begin
            prev_ok_q   <= prev_ok_d;
            prev_pc_q   <= prev_pc_d;
            prev_word_q <= prev_word_d;
        end
    end

    assign shape_hit = rv_valid && rv_dbcc && (rv_disp == LOOP_DISP) && prev_ok_q
                       && (rv_pc == prev_pc_q + ADDR_W'(INSTR_BYTES))
                       && !exc_req && !in_loop;
    assign body_pc   = prev_pc_q;
    assign body_word = prev_word_q;
endmodule

// File: rtl/loop_fetch_gate.sv
module loop_fetch_gate #(
    parameter int                ADDR_W      = 32,
    parameter int                WORD_W      = 16,
    parameter int                DISP_W      = 16,
    parameter int                CNT_W       = 16,
    parameter logic [DISP_W-1:0] LOOP_DISP   = 16'hFFFC,
    parameter int                INSTR_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rv_valid,
    input  logic [ADDR_W-1:0] rv_pc,
    input  logic [WORD_W-1:0] rv_word,
    input  logic              rv_single,
    input  logic              rv_flow,
    input  logic              rv_dbcc,
    input  logic [DISP_W-1:0] rv_disp,
    input  logic              cond_met,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              iter_done,
    input  logic              exc_req,
    output logic              fetch_suppress,
    output logic              loop_active,
    output logic [WORD_W-1:0] replay_word,
    output logic              cnt_we,
    output logic [CNT_W-1:0]  cnt_wdata,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              exc_exit,
    output logic [ADDR_W-1:0] resume_pc
);
    import loop_fetch_pkg::*;

    localparam int BRANCH_BYTES = 2 * INSTR_BYTES;

    typedef struct packed {
        loop_state_e       state;
        logic [ADDR_W-1:0] body_pc;
        logic [ADDR_W-1:0] fall_pc;
        logic [WORD_W-1:0] word;
    } gate_t;

    gate_t r_d, r_q;

    logic              shape_hit;
    logic [ADDR_W-1:0] det_pc;
    logic [WORD_W-1:0] det_word;
    logic [CNT_W-1:0]  cnt_dec;
    logic              take_branch;
    logic              in_loop;

    assign in_loop = (r_q.state != LS_IDLE);

    loop_shape_detect #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DISP_W(DISP_W),
        .LOOP_DISP(LOOP_DISP), .INSTR_BYTES(INSTR_BYTES)
    ) i_detect (
        .clk(clk), .rst(rst),
        .rv_valid(rv_valid), .rv_pc(rv_pc), .rv_word(rv_word),
        .rv_single(rv_single), .rv_flow(rv_flow), .rv_dbcc(rv_dbcc),
        .rv_disp(rv_disp), .exc_req(exc_req), .in_loop(in_loop),
        .shape_hit(shape_hit), .body_pc(det_pc), .body_word(det_word)
    );

    loop_iter_eval #(.CNT_W(CNT_W)) i_eval (
        .cnt_in(cnt_in), .cond_met(cond_met),
        .cnt_dec(cnt_dec), .take_branch(take_branch)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            LS_IDLE: begin
                if (shape_hit && take_branch) begin
                    r_d.state   = LS_LOOP;
                    r_d.body_pc = det_pc;
                    r_d.fall_pc = rv_pc + ADDR_W'(BRANCH_BYTES);
                    r_d.word    = det_word;
                end
            end
            LS_LOOP: begin
                if (exc_req) begin
                    r_d.state = LS_IDLE;
                end else if (iter_done && !take_branch) begin
                    r_d.state = LS_EXIT;
                end
            end
            LS_EXIT: r_d.state = LS_IDLE;
            default: r_d.state = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: LS_IDLE, body_pc: '0, fall_pc: '0, word: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign loop_active    = (r_q.state == LS_LOOP);
    assign fetch_suppress = in_loop && !exc_req;
    assign replay_word    = r_q.word;
    assign cnt_we         = loop_active && iter_done && !exc_req && !cond_met;
    assign cnt_wdata      = cnt_dec;
    assign redirect_valid = (r_q.state == LS_EXIT) && !exc_req;
    assign redirect_pc    = r_q.fall_pc;
    assign exc_exit       = in_loop && exc_req;
    assign resume_pc      = loop_active ? r_q.body_pc : r_q.fall_pc;
endmodule

// File: rtl/loop_fetch_gate_chk.sv
module loop_fetch_gate_chk #(
    parameter int                ADDR_W    = 32,
    parameter int                DISP_W    = 16,
    parameter logic [DISP_W-1:0] LOOP_DISP = 16'hFFFC
) (
    input logic              clk,
    input logic              rst,
    input logic              rv_valid,
    input logic              rv_dbcc,
    input logic [DISP_W-1:0] rv_disp,
    input logic              exc_req,
    input logic              loop_active,
    input logic              fetch_suppress,
    input logic              cnt_we,
    input logic              redirect_valid,
    input logic              exc_exit,
    input logic [ADDR_W-1:0] redirect_pc
);
    AST_ENTRY_SHAPE: assert property (@(posedge clk) disable iff (rst)
        $rose(loop_active) |-> $past(rv_valid && rv_dbcc && rv_disp == LOOP_DISP && !exc_req)); // R1
    AST_SUPPRESS_IN_LOOP: assert property (@(posedge clk) disable iff (rst)
        (loop_active && !exc_req) |-> fetch_suppress); // R3
    AST_WB_IN_LOOP: assert property (@(posedge clk) disable iff (rst)
        cnt_we |-> (loop_active && !exc_req)); // R4
    AST_EXC_RELEASE: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> !fetch_suppress); // R5
    AST_EXC_LEAVE: assert property (@(posedge clk) disable iff (rst)
        exc_exit |=> (!loop_active && !redirect_valid)); // R5
    AST_REDIRECT_AFTER_LOOP: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> ($past(loop_active) && !loop_active && fetch_suppress)); // R6
    AST_REDIRECT_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> (!redirect_valid && !fetch_suppress && $stable(redirect_pc))); // R6
endmodule

bind loop_fetch_gate loop_fetch_gate_chk #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .LOOP_DISP(LOOP_DISP)
) i_chk (
    .clk(clk), .rst(rst), .rv_valid(rv_valid), .rv_dbcc(rv_dbcc),
    .rv_disp(rv_disp), .exc_req(exc_req), .loop_active(loop_active),
    .fetch_suppress(fetch_suppress), .cnt_we(cnt_we),
    .redirect_valid(redirect_valid), .exc_exit(exc_exit),
    .redirect_pc(redirect_pc)
);

// File: tb/test_loop_fetch_gate.sv
module test_loop_fetch_gate;
    logic        clk = 1'b0;
    logic        rst;
    logic        rv_valid, rv_single, rv_flow, rv_dbcc, cond_met, iter_done, exc_req;
    logic [31:0] rv_pc;
    logic [15:0] rv_word, rv_disp, cnt_in;
    logic        fetch_suppress, loop_active, cnt_we, redirect_valid, exc_exit;
    logic [15:0] replay_word, cnt_wdata;
    logic [31:0] redirect_pc, resume_pc;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    loop_fetch_gate i_loop_fetch_gate (
        .clk(clk), .rst(rst), .rv_valid(rv_valid), .rv_pc(rv_pc), .rv_word(rv_word),
        .rv_single(rv_single), .rv_flow(rv_flow), .rv_dbcc(rv_dbcc), .rv_disp(rv_disp),
        .cond_met(cond_met), .cnt_in(cnt_in), .iter_done(iter_done), .exc_req(exc_req),
        .fetch_suppress(fetch_suppress), .loop_active(loop_active), .replay_word(replay_word),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .exc_exit(exc_exit), .resume_pc(resume_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rv_valid = 0; rv_pc = 0; rv_word = 0; rv_single = 0; rv_flow = 0;
        rv_dbcc = 0; rv_disp = 0; cond_met = 0; cnt_in = 0; iter_done = 0; exc_req = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic retire(input logic [31:0] pc, input logic [15:0] word, input logic single,
                          input logic flow, input logic dbcc, input logic [15:0] disp,
                          input logic cond, input logic [15:0] cnt);
        rv_valid = 1; rv_pc = pc; rv_word = word; rv_single = single; rv_flow = flow;
        rv_dbcc = dbcc; rv_disp = disp; cond_met = cond; cnt_in = cnt;
        #1;
        check("R7 normal first pass", 32'(fetch_suppress), 0);
        tick();
        idle_inputs();
    endtask

    task automatic enter_loop(input logic [31:0] base, input logic [15:0] word);
        retire(base, word, 1, 0, 0, 16'h0, 0, 16'h0);
        retire(base + 2, 16'h51C8, 1, 1, 1, 16'hFFFC, 0, 16'h0005);
        check("R1 loop entered", 32'(loop_active), 1);
        check("R3 fetch suppressed", 32'(fetch_suppress), 1);
        check("R3 replay word", 32'(replay_word), 32'(word));
    endtask

    task automatic iterate(input logic cond, input logic [15:0] cnt, input logic exp_we,
                           input logic [15:0] exp_val, input string tag);
        iter_done = 1; cond_met = cond; cnt_in = cnt;
        #1;
        check(tag, 32'(cnt_we), 32'(exp_we));
        if (exp_we) check(tag, 32'(cnt_wdata), 32'(exp_val));
        tick();
        idle_inputs();
    endtask

    task automatic t_reset();
        check("R8 loop_active reset", 32'(loop_active), 0);
        check("R8 fetch_suppress reset", 32'(fetch_suppress), 0);
        check("R8 redirect reset", 32'(redirect_valid), 0);
        check("R8 cnt_we reset", 32'(cnt_we), 0);
    endtask

    task automatic t_bad_disp();
        retire(32'h200, 16'h3A10, 1, 0, 0, 0, 0, 0);
        retire(32'h202, 16'h51C8, 1, 1, 1, 16'hFFFA, 0, 16'h0005);
        check("R1 other displacement no entry", 32'(loop_active), 0);
    endtask

    task automatic t_bad_body();
        retire(32'h300, 16'h3A10, 0, 0, 0, 0, 0, 0);
        retire(32'h302, 16'h51C8, 1, 1, 1, 16'hFFFC, 0, 16'h0005);
        check("R2 multi-word body no entry", 32'(loop_active), 0);
        retire(32'h400, 16'h6002, 1, 1, 0, 0, 0, 0);
        retire(32'h402, 16'h51C8, 1, 1, 1, 16'hFFFC, 0, 16'h0005);
        check("R2 flow-changing body no entry", 32'(loop_active), 0);
    endtask

    task automatic t_not_taken();
        retire(32'h500, 16'h3A10, 1, 0, 0, 0, 0, 0);
        retire(32'h502, 16'h51C8, 1, 1, 1, 16'hFFFC, 0, 16'h0000);
        check("R7 expiring first pass no entry", 32'(loop_active), 0);
        retire(32'h600, 16'h3A10, 1, 0, 0, 0, 0, 0);
        retire(32'h602, 16'h51C8, 1, 1, 1, 16'hFFFC, 1, 16'h0009);
        check("R7 condition-true first pass no entry", 32'(loop_active), 0);
    endtask

    task automatic t_expiry();
        enter_loop(32'h1000, 16'h10D8);
        iterate(0, 16'h0002, 1, 16'h0001, "R4 decrement 2");
        check("R4 still looping", 32'(loop_active), 1);
        iterate(0, 16'h0001, 1, 16'h0000, "R4 decrement 1");
        check("R4 zero keeps looping", 32'(loop_active), 1);
        iterate(0, 16'h0000, 1, 16'hFFFF, "R4 expiry write");
        check("R6 loop_active low", 32'(loop_active), 0);
        check("R6 redirect valid", 32'(redirect_valid), 1);
        check("R6 redirect pc", redirect_pc, 32'h1006);
        check("R6 suppress held", 32'(fetch_suppress), 1);
        tick();
        check("R6 fetch resumed", 32'(fetch_suppress), 0);
        check("R6 redirect one cycle", 32'(redirect_valid), 0);
    endtask

    task automatic t_cond_exit();
        enter_loop(32'h2000, 16'h4298);
        tick();
        check("R3 idle cycle keeps loop", 32'(loop_active), 1);
        iterate(1, 16'h0007, 0, 16'h0, "R4 condition true no write");
        check("R6 redirect after condition", 32'(redirect_valid), 1);
        check("R6 redirect pc", redirect_pc, 32'h2006);
        tick();
        check("R6 fetch resumed", 32'(fetch_suppress), 0);
    endtask

    task automatic t_exception();
        enter_loop(32'h3000, 16'h20C1);
        exc_req = 1; iter_done = 1; cnt_in = 16'h0004;
        #1;
        check("R5 suppress released same cycle", 32'(fetch_suppress), 0);
        check("R5 exc_exit", 32'(exc_exit), 1);
        check("R5 resume pc", resume_pc, 32'h3000);
        check("R5 no write-back", 32'(cnt_we), 0);
        tick();
        idle_inputs();
        check("R5 loop left", 32'(loop_active), 0);
        check("R5 no redirect", 32'(redirect_valid), 0);
        enter_loop(32'h3100, 16'h20C1);
        exc_req = 1;
        #1;
        check("R5 exception without iteration", 32'(fetch_suppress), 0);
        tick();
        idle_inputs();
        check("R5 loop left", 32'(loop_active), 0);
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        #2;
        rst = 0;
        t_reset();
        t_bad_disp();
        t_bad_body();
        t_not_taken();
        t_expiry();
        t_cond_exit();
        t_exception();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule